// File: doc/BRIEF.md
# UART Bit-Rate Generator with Receive Timeout

This block produces the timing enables that a UART's transmit and receive engines run from. The reference clock can first be divided by eight. A 16-bit divisor then turns it into an oversample tick. An 8-bit per-bit divider counts those oversample ticks and marks every bit boundary with a baud tick.

The divisor and divider are written through simple load strobes. A divider value below four is illegal and is refused. A divisor of zero stops all ticks.

The same block also tracks idle time on the receive side. Each received-character pulse arms a counter that expires after four character times. A character time is the frame length in bits for the programmed data width, stop-bit count and parity setting. When the counter expires, the block emits a one-cycle timeout event.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted, and after its release, all three outputs are low. Reset leaves the divisor at 651 (0x28B) and the divider at 15. With the prescale input low, the oversample tick therefore repeats every 651 cycles and the baud tick every 10416 cycles.
- R2: In steady state, the oversample tick is a one-cycle pulse. It repeats every divisor × P clock cycles, where P is 8 when `pre8_sel` is 1 and 1 when it is 0.
- R3: A baud tick is only ever high in a cycle where the oversample tick is also high. It occurs on every (divider+1)-th oversample tick, so its period is divisor × (divider+1) × P cycles.
- R4: A cycle with `div_wr` high loads `div_wdata` as the new divisor; any value is accepted. A cycle with `bdiv_wr` high loads `bdiv_wdata` as the new divider when that value is 4 or more. The new setting governs every tick period that starts after the next baud tick.
- R5: A divider write whose value is 0, 1, 2 or 3 is ignored, and the previous divider stays in force.
- R6: While the divisor is 0, neither the oversample tick nor the baud tick is ever raised.
- R7: The frame length F is 1, plus the data bits, plus 1 or 2 stop bits, plus 1 if `parity_en` is 1. The data bits are 6, 7, 8 or 8 for `dbits_sel` = 0, 1, 2, 3. Two stop bits are used when `stop2_sel` is 1. `rx_timeout` rises in the cycle after the 4·F-th baud tick counted after an `rx_char` pulse. A tick in the same cycle as the pulse is not counted.
- R8: An `rx_char` pulse restarts the count from zero, even while a timeout is pending. This holds when it falls in a baud-tick cycle. No timeout is raised in the cycle after an `rx_char` pulse.
- R9: `rx_timeout` is a single-cycle pulse. It is not raised again until another `rx_char` pulse has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre8_sel | input | 1 | 1 selects the divide-by-8 prescaler |
| div_wr | input | 1 | Load strobe for the divisor |
| div_wdata | input | 16 | Divisor write value |
| bdiv_wr | input | 1 | Load strobe for the per-bit divider |
| bdiv_wdata | input | 8 | Per-bit divider write value |
| dbits_sel | input | 2 | Data width code: 0=6, 1=7, 2=8, 3=8 bits |
| stop2_sel | input | 1 | 1 selects two stop bits |
| parity_en | input | 1 | 1 adds a parity bit to the frame |
| rx_char | input | 1 | One-cycle pulse per received character |
| os_tick | output | 1 | Oversample tick |
| baud_tick | output | 1 | Bit-boundary tick |
| rx_timeout | output | 1 | Receive timeout event |

## Verification
A received-character pulse and a baud tick can land in the same cycle. The tick must then not count toward the new timeout window, and any timeout about to expire must be cancelled. The bench provokes this by arming the timeout, letting it run to within two ticks of expiry, and then raising `rx_char` exactly in a cycle where `baud_tick` is high. It then counts the baud ticks seen after that cycle, and requires the timeout to appear in the cycle after the 4·F-th counted tick.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

  // Data width codes as seen on the dbits_sel input
  typedef enum logic [1:0] {
    DW_6  = 2'd0,
    DW_7  = 2'd1,
    DW_8  = 2'd2,
    DW_8B = 2'd3
  } data_width_e;

  localparam int unsigned MAX_FRAME_BITS = 12;
  localparam int unsigned FRAME_W        = 4;

  // Start bit + data bits + stop bits + optional parity bit
  function automatic logic [FRAME_W-1:0] frame_bits(
    input logic [1:0] dsel,
    input logic       two_stop,
    input logic       par
  );
    logic [FRAME_W-1:0] dbits;
    case (data_width_e'(dsel))
      DW_6:    dbits = FRAME_W'(6);
      DW_7:    dbits = FRAME_W'(7);
      default: dbits = FRAME_W'(8);
    endcase
    return FRAME_W'(1) + dbits + (two_stop ? FRAME_W'(2) : FRAME_W'(1))
           + FRAME_W'(par);
  endfunction

endpackage

// File: rtl/ubg_cfg_regs.sv
module ubg_cfg_regs #(
  parameter int unsigned     DIV_W    = 16,
  parameter int unsigned     BDIV_W   = 8,
  parameter logic [DIV_W-1:0]  DIV_RST  = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'd15,
  parameter int unsigned     BDIV_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              bdiv_wr,
  input  logic [BDIV_W-1:0] bdiv_wdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [BDIV_W-1:0] bdiv_q
);

  logic [DIV_W-1:0]  div_d;
  logic [BDIV_W-1:0] bdiv_d;
  logic              bdiv_legal;

  always_comb begin
    bdiv_legal = (bdiv_wdata >= BDIV_W'(BDIV_MIN));
    div_d      = div_wr ? div_wdata : div_q;
    bdiv_d     = (bdiv_wr && bdiv_legal) ? bdiv_wdata : bdiv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      div_q  <= div_d;
      bdiv_q <= bdiv_d;
    end
  end

endmodule

// File: rtl/ubg_tick_chain.sv
module ubg_tick_chain #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned BDIV_W    = 8,
  parameter int unsigned PRE_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_sel,
  input  logic [DIV_W-1:0]  div_q,
  input  logic [BDIV_W-1:0] bdiv_q,
  output logic              os_tick,
  output logic              baud_tick
);

  localparam int unsigned PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

  logic src_en;

  generate
    if (PRE_RATIO > 1) begin : g_pre
      logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;
      logic             pre_wrap;
      always_comb begin
        pre_wrap  = (pre_cnt_q == PRE_W'(PRE_RATIO - 1));
        pre_cnt_d = pre_wrap ? '0 : pre_cnt_q + PRE_W'(1);
        src_en    = pre_sel ? pre_wrap : 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt_q <= '0;
        else        pre_cnt_q <= pre_cnt_d;
      end
    end else begin : g_nopre
      logic unused_sel;
      always_comb begin
        unused_sel = pre_sel;
        src_en     = 1'b1;
      end
    end
  endgenerate

  logic [DIV_W-1:0]  cd_cnt_q, cd_cnt_d;
  logic [BDIV_W-1:0] bt_cnt_q, bt_cnt_d;
  logic              div_zero, os_hit, bit_hit;

  always_comb begin
    div_zero = (div_q == '0);
    os_hit   = src_en && !div_zero && (cd_cnt_q >= (div_q - DIV_W'(1)));
    bit_hit  = os_hit && (bt_cnt_q >= bdiv_q);

    if (div_zero)    cd_cnt_d = '0;
    else if (os_hit) cd_cnt_d = '0;
    else if (src_en) cd_cnt_d = cd_cnt_q + DIV_W'(1);
    else             cd_cnt_d = cd_cnt_q;

    if (bit_hit)     bt_cnt_d = '0;
    else if (os_hit) bt_cnt_d = bt_cnt_q + BDIV_W'(1);
    else             bt_cnt_d = bt_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_cnt_q  <= '0;
      bt_cnt_q  <= '0;
      os_tick   <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      cd_cnt_q  <= cd_cnt_d;
      bt_cnt_q  <= bt_cnt_d;
      os_tick   <= os_hit;
      baud_tick <= bit_hit;
    end
  end

endmodule

// File: rtl/ubg_rx_timeout.sv
module ubg_rx_timeout #(
  parameter int unsigned TO_CHARS = 4,
  parameter int unsigned FRAME_W  = 4,
  parameter int unsigned MAX_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               rx_char,
  input  logic [FRAME_W-1:0] frame_len,
  output logic               rx_timeout
);

  localparam int unsigned CNT_W = $clog2(TO_CHARS * MAX_BITS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             armed_q, armed_d, fire;

  always_comb begin
    limit   = CNT_W'(TO_CHARS) * CNT_W'(frame_len);
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    if (rx_char) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && baud_tick) begin
      if (cnt_q >= limit - CNT_W'(1)) begin
        fire    = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      rx_timeout <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      armed_q    <= armed_d;
      rx_timeout <= fire;
    end
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned       DIV_W     = 16,
  parameter int unsigned       BDIV_W    = 8,
  parameter int unsigned       PRE_RATIO = 8,
  parameter int unsigned       TO_CHARS  = 4,
  parameter int unsigned       BDIV_MIN  = 4,
  parameter logic [DIV_W-1:0]  DIV_RST   = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST  = 8'd15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre8_sel,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              bdiv_wr,
  input  logic [BDIV_W-1:0] bdiv_wdata,
  input  logic [1:0]        dbits_sel,
  input  logic              stop2_sel,
  input  logic              parity_en,
  input  logic              rx_char,
  output logic              os_tick,
  output logic              baud_tick,
  output logic              rx_timeout
);

  import uart_baud_pkg::*;

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DIV_W-1:0]   div_q;
  logic [BDIV_W-1:0]  bdiv_q;
  logic [FRAME_W-1:0] frame_len;

  assign frame_len = frame_bits(dbits_sel, stop2_sel, parity_en);

  ubg_cfg_regs #(
    .DIV_W(DIV_W), .BDIV_W(BDIV_W), .DIV_RST(DIV_RST),
    .BDIV_RST(BDIV_RST), .BDIV_MIN(BDIV_MIN)
  ) cfg_i (
    .clk(clk), .rst_n(rst_int_n),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .bdiv_wr(bdiv_wr), .bdiv_wdata(bdiv_wdata),
    .div_q(div_q), .bdiv_q(bdiv_q)
  );

  ubg_tick_chain #(
    .DIV_W(DIV_W), .BDIV_W(BDIV_W), .PRE_RATIO(PRE_RATIO)
  ) chain_i (
    .clk(clk), .rst_n(rst_int_n), .pre_sel(pre8_sel),
    .div_q(div_q), .bdiv_q(bdiv_q),
    .os_tick(os_tick), .baud_tick(baud_tick)
  );

  ubg_rx_timeout #(
    .TO_CHARS(TO_CHARS), .FRAME_W(FRAME_W), .MAX_BITS(MAX_FRAME_BITS)
  ) tmo_i (
    .clk(clk), .rst_n(rst_int_n), .baud_tick(baud_tick),
    .rx_char(rx_char), .frame_len(frame_len), .rx_timeout(rx_timeout)
  );

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned BDIV_W   = 8,
  parameter int unsigned BDIV_MIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              os_tick,
  input logic              baud_tick,
  input logic              rx_char,
  input logic              rx_timeout,
  input logic [DIV_W-1:0]  div_q,
  input logic [BDIV_W-1:0] bdiv_q
);

  // R3
  baud_on_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> os_tick);

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) == '0) |-> !os_tick);

  // R5
  bdiv_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bdiv_q >= BDIV_W'(BDIV_MIN));

  // R9
  to_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |=> !rx_timeout);

  // R7
  to_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> $past(baud_tick));

  // R8
  rearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char |=> !rx_timeout);

endmodule

bind uart_baud_gen uart_baud_gen_chk #(
  .DIV_W(DIV_W), .BDIV_W(BDIV_W), .BDIV_MIN(BDIV_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .baud_tick(baud_tick),
  .rx_char(rx_char), .rx_timeout(rx_timeout),
  .div_q(div_q), .bdiv_q(bdiv_q)
);

// File: tb/uart_baud_gen_tb_top.sv
module uart_baud_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre8_sel = 1'b0;
  logic        div_wr = 1'b0;
  logic [15:0] div_wdata = '0;
  logic        bdiv_wr = 1'b0;
  logic [7:0]  bdiv_wdata = '0;
  logic [1:0]  dbits_sel = '0;
  logic        stop2_sel = 1'b0;
  logic        parity_en = 1'b0;
  logic        rx_char = 1'b0;
  logic        os_tick, baud_tick, rx_timeout;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  uart_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pre8_sel(pre8_sel),
    .div_wr(div_wr), .div_wdata(div_wdata),
    .bdiv_wr(bdiv_wr), .bdiv_wdata(bdiv_wdata),
    .dbits_sel(dbits_sel), .stop2_sel(stop2_sel), .parity_en(parity_en),
    .rx_char(rx_char), .os_tick(os_tick), .baud_tick(baud_tick),
    .rx_timeout(rx_timeout)
  );

  function automatic int exp_os(input int dv, input bit pre);
    return dv * (pre ? 8 : 1);
  endfunction

  function automatic int exp_baud(input int dv, input int bd, input bit pre);
    return dv * (bd + 1) * (pre ? 8 : 1);
  endfunction

  function automatic int exp_frame(input int ds, input bit s2, input bit par);
    int db;
    db = (ds == 0) ? 6 : (ds == 1) ? 7 : 8;
    return 1 + db + (s2 ? 2 : 1) + (par ? 1 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [15:0] v);
    @(negedge clk); div_wr = 1'b1; div_wdata = v;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic wr_bdiv(input logic [7:0] v);
    @(negedge clk); bdiv_wr = 1'b1; bdiv_wdata = v;
    @(negedge clk); bdiv_wr = 1'b0;
  endtask

  // Settle on one baud tick, then time the next os and baud periods
  task automatic measure(input int dv, input int bd, input bit pre, input string req);
    int cyc, oss, ocyc;
    do @(negedge clk); while (!baud_tick);
    ocyc = 0;
    do begin @(negedge clk); ocyc++; end while (!os_tick);
    check(ocyc == exp_os(dv, pre), {req, " R2 os period"}, ocyc, exp_os(dv, pre));
    do @(negedge clk); while (!baud_tick);
    cyc = 0; oss = 0;
    do begin
      @(negedge clk); cyc++;
      if (os_tick) oss++;
    end while (!baud_tick);
    check(cyc == exp_baud(dv, bd, pre), {req, " R3 baud period"}, cyc, exp_baud(dv, bd, pre));
    check(oss == bd + 1, {req, " R3 os per baud"}, oss, bd + 1);
  endtask

  // Pulse rx_char (optionally in a baud-tick cycle) and count ticks to timeout
  task automatic arm_and_time(input bit collide, input int frame, input string req);
    int cnt; bit last_tick;
    if (collide) begin
      while (!baud_tick) @(negedge clk);
    end
    rx_char = 1'b1;
    @(negedge clk); rx_char = 1'b0;
    check(!rx_timeout, "R8 quiet after rx_char", rx_timeout, 0);
    cnt = 0; last_tick = 1'b0;
    while (!rx_timeout && cnt <= 4 * frame + 2) begin
      last_tick = baud_tick;
      if (baud_tick) cnt++;
      @(negedge clk);
    end
    check(cnt == 4 * frame && last_tick, req, cnt, 4 * frame);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int zcnt, fr, quiet;
    void'($urandom(32'h5eed_0a11));
    // R1: outputs low in reset and just after release
    repeat (3) @(negedge clk);
    check(!os_tick && !baud_tick && !rx_timeout, "R1 in reset", {os_tick, baud_tick, rx_timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!os_tick && !baud_tick && !rx_timeout, "R1 after release", {os_tick, baud_tick, rx_timeout}, 0);
    measure(651, 15, 1'b0, "R1 reset defaults");

    // R4 directed writes with prescaler
    pre8_sel = 1'b1;
    wr_div(16'd5); wr_bdiv(8'd7);
    measure(5, 7, 1'b1, "R4 directed");

    // R5: illegal divider values ignored
    wr_bdiv(8'd3); wr_bdiv(8'd0);
    measure(5, 7, 1'b1, "R5 illegal divider ignored");
    wr_bdiv(8'd4);
    measure(5, 4, 1'b1, "R4 minimum divider");

    // Random legal settings
    for (int i = 0; i < 6; i++) begin
      int dv, bd; bit pre;
      dv = 1 + int'($urandom_range(29));
      bd = 4 + int'($urandom_range(5));
      pre = 1'($urandom_range(1));
      pre8_sel = pre;
      wr_div(16'(dv)); wr_bdiv(8'(bd));
      measure(dv, bd, pre, "R4 random");
    end

    // R6: divisor zero stops all ticks
    wr_div(16'd0);
    repeat (3) @(negedge clk);
    zcnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (os_tick || baud_tick) zcnt++;
    end
    check(zcnt == 0, "R6 no ticks with zero divisor", zcnt, 0);

    // Timeout: fast baud (every 5 cycles)
    pre8_sel = 1'b0;
    wr_div(16'd1); wr_bdiv(8'd4);
    measure(1, 4, 1'b0, "R4 fast");
    for (int k = 0; k < 4; k++) begin
      int ds; bit s2, par;
      ds = k; s2 = k[0]; par = (k != 0);
      dbits_sel = 2'(ds); stop2_sel = s2; parity_en = par;
      fr = exp_frame(ds, s2, par);
      @(negedge clk);
      arm_and_time(1'b0, fr, "R7 timeout after 4F ticks");
    end

    // R8: rearm in a baud-tick cycle two ticks before expiry
    dbits_sel = 2'd2; stop2_sel = 1'b0; parity_en = 1'b0;
    fr = exp_frame(2, 1'b0, 1'b0);
    @(negedge clk);
    rx_char = 1'b1; @(negedge clk); rx_char = 1'b0;
    begin
      int seen;
      seen = 0;
      while (seen < 4 * fr - 2) begin
        if (baud_tick) seen++;
        @(negedge clk);
      end
    end
    arm_and_time(1'b1, fr, "R8 collision restart");

    // R9: no repeat timeout without a new character
    quiet = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rx_timeout) quiet++;
    end
    check(quiet == 0, "R9 no repeat timeout", quiet, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule